// File: doc/BRIEF.md
# VLAN-Indexed Slice Ingress Classifier

This block sits at the receive side of a virtualised packet router. Each incoming frame arrives as a descriptor: a buffer handle, the headers already split into fields (tag protocol, VLAN tag, EtherType, IP protocol, tunnel addresses and ports), the low nibble of the destination MAC and the position of the inner frame. The block checks that the frame is a VLAN-tagged IPv4 UDP tunnel packet. It then uses the low eleven VLAN bits to index a slice table. Each table entry gives the slice's processing code option, a pointer to its private data region and the region's size.

Frames that fail the format check, or that land on a slice that is switched off or badly configured, are dropped and counted. Every other frame leaves as one metadata record on a valid/ready stream. The record holds the handle, the inner frame position, a composite slice identifier, the tunnel identity, the code option and the data pointer. A host port rewrites table entries one whole entry per cycle. Three saturating counters report accepted frames and the two kinds of drop.

Top module: `sic_ingress_classifier`

## Requirements
- R1: After reset, `out_valid` is 0, all three counters are 0, `in_ready` is 1, and every table entry has code option 0, so a frame to any slice is dropped as an invalid slice.
- R2: A frame is well formed only if the tag protocol is 0x8100, the EtherType is 0x0800 and the IP protocol is 17. Any other frame is dropped and adds one to `cnt_bad_fmt`. This holds whatever its slice entry contains.
- R3: The table index is `in_vlan_tci[10:0]`. Bits 15..11 of the tag have no effect on the lookup.
- R4: The output slice identifier is `{1'b0, in_rx_id[3:0], in_vlan_tci[10:0]}`. Bit 15 is always 0.
- R5: A well-formed frame whose entry has code option 0 is dropped and adds one to `cnt_bad_slice`.
- R6: A well-formed frame whose entry has a data size below MIN_DATA_BYTES (56) is dropped and adds one to `cnt_bad_slice`. The same applies when its data pointer is not a multiple of PTR_ALIGN (4), meaning pointer bits [1:0] are not 00.
- R7: An accepted frame produces exactly one output record. The record holds the input handle, inner offset, inner length, IP source, UDP source port and UDP destination port unchanged, together with the entry's code option and data pointer. Records leave in arrival order.
- R8: `in_ready` is 1 exactly when the output register is empty or being drained. While `out_valid` is 1 and `out_ready` is 0, every output field holds steady and no frame is taken.
- R9: Each frame taken adds one to exactly one counter: `cnt_accept`, `cnt_bad_fmt` or `cnt_bad_slice`.
- R10: Each counter stops at its all-ones value and does not wrap.
- R11: A table write and a lookup of the same entry on the same clock edge use the old contents. Any lookup on a later edge sees the whole new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Descriptor present |
| in_ready | output | 1 | Descriptor taken on this edge when in_valid is high |
| in_handle | input | HANDLE_W | Frame buffer handle |
| in_rx_id | input | 4 | Low nibble of the received destination MAC |
| in_tpid | input | 16 | Outer tag protocol identifier |
| in_vlan_tci | input | 16 | VLAN tag control field |
| in_ethertype | input | 16 | EtherType after the tag |
| in_ip_proto | input | 8 | IP protocol number |
| in_ip_src | input | 32 | Outer IP source address |
| in_udp_sport | input | 16 | Tunnel UDP source port |
| in_udp_dport | input | 16 | Tunnel UDP destination port |
| in_inner_off | input | 16 | Offset of the inner frame |
| in_inner_len | input | 16 | Length of the inner frame |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_idx | input | 11 | Table entry written |
| tbl_wr_code | input | 4 | Code option to store |
| tbl_wr_ptr | input | 32 | Slice data pointer to store |
| tbl_wr_size | input | 32 | Slice data size in bytes to store |
| out_valid | output | 1 | Record present |
| out_ready | input | 1 | Downstream takes the record |
| out_handle | output | HANDLE_W | Frame buffer handle |
| out_inner_off | output | 16 | Inner frame offset |
| out_inner_len | output | 16 | Inner frame length |
| out_slice_id | output | 16 | Composite slice identifier |
| out_ip_src | output | 32 | Tunnel IP source |
| out_udp_sport | output | 16 | Tunnel UDP source port |
| out_udp_dport | output | 16 | Tunnel UDP destination port |
| out_code | output | 4 | Slice code option |
| out_data_ptr | output | 32 | Slice data pointer |
| cnt_accept | output | CNT_W | Accepted frames |
| cnt_bad_fmt | output | CNT_W | Frames dropped for format |
| cnt_bad_slice | output | CNT_W | Frames dropped for slice state |

## Verification
The bench builds the block with HANDLE_W at 24, MIN_DATA_BYTES at 56 and PTR_ALIGN at 4, and narrows CNT_W to 6. With that width, a few hundred mixed frames drive all three counters into saturation, which brings the stop-at-all-ones behaviour within reach. Random traffic is spread over a small pool of slice indices, with random upper VLAN bits and random table rewrites. This causes repeated hits on freshly rewritten entries, including writes on the same edge as a lookup. Directed cases cover the data-size boundary at 55 and 56 and a misaligned pointer. They also cover each single broken header field and a long output stall.

// File: rtl/sic_pkg.sv
// Shared constants and types of the slice ingress classifier.
// Assumes: slice table indexed by an 11-bit VLAN field, 4-bit receive ID.
package sic_pkg;
    localparam int VID_BITS   = 11;
    localparam int RXID_BITS  = 4;
    localparam int SLICE_W    = 16;
    localparam int CODE_W     = 4;
    localparam int TBL_DEPTH  = 1 << VID_BITS;

    localparam logic [15:0] TPID_VLAN  = 16'h8100;
    localparam logic [15:0] ETYPE_IPV4 = 16'h0800;
    localparam logic [7:0]  PROTO_UDP  = 8'd17;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [31:0]       ptr;
        logic [31:0]       size;
    } slice_ent_t;

    typedef enum logic [1:0] {
        VD_ACCEPT    = 2'd0,
        VD_BAD_FMT   = 2'd1,
        VD_BAD_SLICE = 2'd2
    } verdict_e;
endpackage

// File: rtl/sic_hdr_check.sv
// Header field check: decides whether the descriptor is a tagged IPv4 UDP
// frame, and derives the table index and the composite slice identifier.
// Assumes: fields are already extracted from the frame; purely combinational.
module sic_hdr_check
    import sic_pkg::*;
(
    input  logic [15:0]          tpid,
    input  logic [15:0]          vlan_tci,
    input  logic [15:0]          ethertype,
    input  logic [7:0]           ip_proto,
    input  logic [RXID_BITS-1:0] rx_id,
    output logic                 fmt_ok,
    output logic [VID_BITS-1:0]  tbl_idx,
    output logic [SLICE_W-1:0]   slice_id
);
    logic unused_tci_hi;

    // Format test over the three identifying header fields.
    always_comb begin
        fmt_ok = (tpid == TPID_VLAN) && (ethertype == ETYPE_IPV4) &&
                 (ip_proto == PROTO_UDP);
    end

    // Index from the low VLAN bits; identifier adds the receive ID.
    always_comb begin
        tbl_idx  = vlan_tci[VID_BITS-1:0];
        slice_id = {{(SLICE_W-RXID_BITS-VID_BITS){1'b0}}, rx_id, vlan_tci[VID_BITS-1:0]};
    end

    assign unused_tci_hi = ^vlan_tci[15:VID_BITS];
endmodule

// File: rtl/sic_slice_table.sv
// Slice table: one register row per slice, written whole in one cycle by the
// host port and read combinationally by the lookup.
// Assumes: a write and a read on the same edge return the old row.
module sic_slice_table
    import sic_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [VID_BITS-1:0] wr_idx,
    input  slice_ent_t          wr_ent,
    input  logic [VID_BITS-1:0] rd_idx,
    output slice_ent_t          rd_ent
);
    slice_ent_t rows [TBL_DEPTH];

    // Whole-entry write; reset switches every slice off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TBL_DEPTH; i++) rows[i] <= '0;
        end else if (wr_en) begin
            rows[wr_idx] <= wr_ent;
        end
    end

    // Lookup read port.
    always_comb rd_ent = rows[rd_idx];
endmodule

// File: rtl/sic_verdict.sv
// Verdict: combines the format result with the slice entry's sanity checks.
// Assumes: PTR_ALIGN is a power of two; format failure takes precedence.
module sic_verdict
    import sic_pkg::*;
#(
    parameter int MIN_DATA_BYTES = 56,
    parameter int PTR_ALIGN      = 4
) (
    input  logic       fmt_ok,
    input  slice_ent_t ent,
    output verdict_e   verdict
);
    localparam logic [31:0] ALIGN_MASK = 32'(PTR_ALIGN - 1);
    localparam logic [31:0] MIN_SIZE   = 32'(MIN_DATA_BYTES);

    logic slice_ok;

    // Entry is usable when switched on, large enough and aligned.
    always_comb begin
        slice_ok = (ent.code != '0) && (ent.size >= MIN_SIZE) &&
                   ((ent.ptr & ALIGN_MASK) == 32'd0);
    end

    // Final classification with format first.
    always_comb begin
        if (!fmt_ok)        verdict = VD_BAD_FMT;
        else if (!slice_ok) verdict = VD_BAD_SLICE;
        else                verdict = VD_ACCEPT;
    end
endmodule

// File: rtl/sic_sat_counters.sv
// Bank of saturating event counters, one per bump bit.
// Assumes: at most one increment per counter per cycle.
module sic_sat_counters #(
    parameter int N     = 3,
    parameter int CNT_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N-1:0]              bump,
    output logic [N-1:0][CNT_W-1:0]   count
);
    for (genvar g = 0; g < N; g++) begin : g_cnt
        // Count up on bump, hold at all ones.
        always_ff @(posedge clk) begin
            if (!rst_n)                            count[g] <= '0;
            else if (bump[g] && (count[g] != '1))  count[g] <= count[g] + 1'b1;
        end
    end
endmodule

// File: rtl/sic_ingress_classifier.sv
// Slice ingress classifier top: takes one descriptor per cycle when the output
// register is free, classifies it against the slice table and either loads
// the output record or drops it, bumping one counter per frame taken.
// Assumes: one-deep output register; drops also wait for a free output slot.
module sic_ingress_classifier
    import sic_pkg::*;
#(
    parameter int HANDLE_W       = 24,
    parameter int CNT_W          = 32,
    parameter int MIN_DATA_BYTES = 56,
    parameter int PTR_ALIGN      = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [HANDLE_W-1:0] in_handle,
    input  logic [3:0]          in_rx_id,
    input  logic [15:0]         in_tpid,
    input  logic [15:0]         in_vlan_tci,
    input  logic [15:0]         in_ethertype,
    input  logic [7:0]          in_ip_proto,
    input  logic [31:0]         in_ip_src,
    input  logic [15:0]         in_udp_sport,
    input  logic [15:0]         in_udp_dport,
    input  logic [15:0]         in_inner_off,
    input  logic [15:0]         in_inner_len,
    input  logic                tbl_wr_en,
    input  logic [10:0]         tbl_wr_idx,
    input  logic [3:0]          tbl_wr_code,
    input  logic [31:0]         tbl_wr_ptr,
    input  logic [31:0]         tbl_wr_size,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [HANDLE_W-1:0] out_handle,
    output logic [15:0]         out_inner_off,
    output logic [15:0]         out_inner_len,
    output logic [15:0]         out_slice_id,
    output logic [31:0]         out_ip_src,
    output logic [15:0]         out_udp_sport,
    output logic [15:0]         out_udp_dport,
    output logic [3:0]          out_code,
    output logic [31:0]         out_data_ptr,
    output logic [CNT_W-1:0]    cnt_accept,
    output logic [CNT_W-1:0]    cnt_bad_fmt,
    output logic [CNT_W-1:0]    cnt_bad_slice
);
    localparam int N_CNT = 3;

    logic                  fmt_ok;
    logic [VID_BITS-1:0]   tbl_idx;
    logic [SLICE_W-1:0]    slice_id;
    slice_ent_t            ent;
    slice_ent_t            wr_ent;
    verdict_e              verdict;
    logic                  take;
    logic [N_CNT-1:0]      bump;
    logic [N_CNT-1:0][CNT_W-1:0] counts;

    sic_hdr_check u_hdr (
        .tpid      (in_tpid),
        .vlan_tci  (in_vlan_tci),
        .ethertype (in_ethertype),
        .ip_proto  (in_ip_proto),
        .rx_id     (in_rx_id),
        .fmt_ok    (fmt_ok),
        .tbl_idx   (tbl_idx),
        .slice_id  (slice_id)
    );

    // Pack the host write fields into one table row.
    always_comb wr_ent = '{code: tbl_wr_code, ptr: tbl_wr_ptr, size: tbl_wr_size};

    sic_slice_table u_tbl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (tbl_wr_en),
        .wr_idx (tbl_wr_idx),
        .wr_ent (wr_ent),
        .rd_idx (tbl_idx),
        .rd_ent (ent)
    );

    sic_verdict #(
        .MIN_DATA_BYTES (MIN_DATA_BYTES),
        .PTR_ALIGN      (PTR_ALIGN)
    ) u_vd (
        .fmt_ok  (fmt_ok),
        .ent     (ent),
        .verdict (verdict)
    );

    // Input handshake: free output slot or one draining this cycle.
    always_comb begin
        in_ready = !out_valid || out_ready;
        take     = in_valid && in_ready;
    end

    // Output record register with hold under back-pressure.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_handle    <= '0;
            out_inner_off <= '0;
            out_inner_len <= '0;
            out_slice_id  <= '0;
            out_ip_src    <= '0;
            out_udp_sport <= '0;
            out_udp_dport <= '0;
            out_code      <= '0;
            out_data_ptr  <= '0;
        end else if (take && (verdict == VD_ACCEPT)) begin
            out_valid     <= 1'b1;
            out_handle    <= in_handle;
            out_inner_off <= in_inner_off;
            out_inner_len <= in_inner_len;
            out_slice_id  <= slice_id;
            out_ip_src    <= in_ip_src;
            out_udp_sport <= in_udp_sport;
            out_udp_dport <= in_udp_dport;
            out_code      <= ent.code;
            out_data_ptr  <= ent.ptr;
        end else if (out_ready) begin
            out_valid     <= 1'b0;
        end
    end

    // One counter event per frame taken, chosen by the verdict.
    always_comb begin
        bump    = '0;
        bump[0] = take && (verdict == VD_ACCEPT);
        bump[1] = take && (verdict == VD_BAD_FMT);
        bump[2] = take && (verdict == VD_BAD_SLICE);
    end

    sic_sat_counters #(
        .N     (N_CNT),
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .bump  (bump),
        .count (counts)
    );

    // Counter outputs.
    always_comb begin
        cnt_accept    = counts[0];
        cnt_bad_fmt   = counts[1];
        cnt_bad_slice = counts[2];
    end
endmodule

// File: rtl/sic_ingress_checker.sv
// Property checker for the slice ingress classifier, bound to the top.
// Assumes: observes ports only.
module sic_ingress_checker #(
    parameter int HANDLE_W = 24,
    parameter int CNT_W    = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                out_valid,
    input logic                out_ready,
    input logic [HANDLE_W-1:0] out_handle,
    input logic [15:0]         out_slice_id,
    input logic [31:0]         out_ip_src,
    input logic [3:0]          out_code,
    input logic [31:0]         out_data_ptr,
    input logic [CNT_W-1:0]    cnt_accept,
    input logic [CNT_W-1:0]    cnt_bad_fmt,
    input logic [CNT_W-1:0]    cnt_bad_slice
);
    a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_handle) &&
        $stable(out_slice_id) && $stable(out_ip_src) && $stable(out_code) &&
        $stable(out_data_ptr)));

    a_r4_slice_msb_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_slice_id[15] == 1'b0));

    a_r5_code_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_code != 4'd0));

    a_r6_ptr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_data_ptr[1:0] == 2'b00));

    a_r9_single_event: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({cnt_accept != $past(cnt_accept), cnt_bad_fmt != $past(cnt_bad_fmt),
                    cnt_bad_slice != $past(cnt_bad_slice)}) <= 1);

    a_r10_accept_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_accept == '1) |=> (cnt_accept == '1));

    a_r10_fmt_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_bad_fmt == '1) |=> (cnt_bad_fmt == '1));

    a_r10_slice_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_bad_slice == '1) |=> (cnt_bad_slice == '1));
endmodule

bind sic_ingress_classifier sic_ingress_checker #(
    .HANDLE_W (HANDLE_W),
    .CNT_W    (CNT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_handle    (out_handle),
    .out_slice_id  (out_slice_id),
    .out_ip_src    (out_ip_src),
    .out_code      (out_code),
    .out_data_ptr  (out_data_ptr),
    .cnt_accept    (cnt_accept),
    .cnt_bad_fmt   (cnt_bad_fmt),
    .cnt_bad_slice (cnt_bad_slice)
);

// File: tb/sim_sic_ingress_classifier.sv
module sim_sic_ingress_classifier;
    localparam int HW  = 24;
    localparam int CW  = 6;
    localparam int RW  = HW + 16 + 16 + 16 + 32 + 16 + 16 + 4 + 32;
    localparam int CMAX = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          in_valid = 0, in_ready;
    logic [HW-1:0] in_handle = 0;
    logic [3:0]    in_rx_id = 0;
    logic [15:0]   in_tpid = 0, in_vlan_tci = 0, in_ethertype = 0;
    logic [7:0]    in_ip_proto = 0;
    logic [31:0]   in_ip_src = 0;
    logic [15:0]   in_udp_sport = 0, in_udp_dport = 0, in_inner_off = 0, in_inner_len = 0;
    logic          tbl_wr_en = 0;
    logic [10:0]   tbl_wr_idx = 0;
    logic [3:0]    tbl_wr_code = 0;
    logic [31:0]   tbl_wr_ptr = 0, tbl_wr_size = 0;
    logic          out_valid, out_ready = 1;
    logic [HW-1:0] out_handle;
    logic [15:0]   out_inner_off, out_inner_len, out_slice_id, out_udp_sport, out_udp_dport;
    logic [31:0]   out_ip_src, out_data_ptr;
    logic [3:0]    out_code;
    logic [CW-1:0] cnt_accept, cnt_bad_fmt, cnt_bad_slice;

    sic_ingress_classifier #(.HANDLE_W(HW), .CNT_W(CW), .MIN_DATA_BYTES(56), .PTR_ALIGN(4)) u0 (.*);

    int n_chk = 0, n_bad = 0;
    logic [3:0]  m_code [2048];
    logic [31:0] m_ptr  [2048];
    logic [31:0] m_size [2048];
    logic [RW-1:0] expq [$];
    int m_acc = 0, m_fmt = 0, m_slc = 0;
    int rmode = 1;
    bit took;
    string cur_req = "R7";

    task automatic chk(input bit ok, input string req, input logic [RW-1:0] act, input logic [RW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [RW-1:0] out_rec();
        return {out_handle, out_inner_off, out_inner_len, out_slice_id, out_ip_src,
                out_udp_sport, out_udp_dport, out_code, out_data_ptr};
    endfunction

    // Expected verdict from the requirements: 0 accept, 1 bad format, 2 bad slice.
    function automatic int exp_verdict();
        int ix = int'(in_vlan_tci[10:0]);
        if (!(in_tpid == 16'h8100 && in_ethertype == 16'h0800 && in_ip_proto == 8'd17)) return 1;
        if (m_code[ix] == 0 || m_size[ix] < 56 || m_ptr[ix][1:0] != 2'b00) return 2;
        return 0;
    endfunction

    function automatic logic [RW-1:0] exp_rec();
        int ix = int'(in_vlan_tci[10:0]);
        return {in_handle, in_inner_off, in_inner_len, {1'b0, in_rx_id, in_vlan_tci[10:0]},
                in_ip_src, in_udp_sport, in_udp_dport, m_code[ix], m_ptr[ix]};
    endfunction

    function automatic int sat(input int v);
        return (v >= CMAX) ? CMAX : v + 1;
    endfunction

    task automatic tick();
        if (rmode == 1) out_ready = 1;
        else if (rmode == 2) out_ready = 0;
        else out_ready = ($urandom % 4) != 0;
        #1;
        took = in_valid && in_ready;
        if (took) begin
            int v = exp_verdict();
            if (v == 0) begin expq.push_back(exp_rec()); m_acc = sat(m_acc); end
            else if (v == 1) m_fmt = sat(m_fmt);
            else m_slc = sat(m_slc);
        end
        if (out_valid && out_ready) begin
            logic [RW-1:0] e = '0;
            if (expq.size() > 0) begin
                e = expq.pop_front();
                chk(out_rec() == e, $sformatf("R7 R3 R4 record %s", cur_req), out_rec(), e);
            end else chk(1'b0, "R7 unexpected record", out_rec(), '0);
        end
        if (tbl_wr_en) begin
            m_code[tbl_wr_idx] = tbl_wr_code;
            m_ptr[tbl_wr_idx]  = tbl_wr_ptr;
            m_size[tbl_wr_idx] = tbl_wr_size;
        end
        @(posedge clk);
        @(negedge clk);
        tbl_wr_en = 0;
        chk({cnt_accept, cnt_bad_fmt, cnt_bad_slice} == {CW'(m_acc), CW'(m_fmt), CW'(m_slc)},
            $sformatf("R9 counters %s", cur_req),
            RW'({cnt_accept, cnt_bad_fmt, cnt_bad_slice}), RW'({CW'(m_acc), CW'(m_fmt), CW'(m_slc)}));
    endtask

    task automatic send();
        in_valid = 1;
        do tick(); while (!took);
        in_valid = 0;
    endtask

    task automatic set_pkt(input logic [15:0] tci);
        in_handle = HW'($urandom); in_rx_id = 4'($urandom);
        in_tpid = 16'h8100; in_vlan_tci = tci; in_ethertype = 16'h0800; in_ip_proto = 8'd17;
        in_ip_src = $urandom; in_udp_sport = 16'($urandom); in_udp_dport = 16'($urandom);
        in_inner_off = 16'($urandom); in_inner_len = 16'($urandom);
    endtask

    task automatic set_wr(input logic [10:0] ix, input logic [3:0] c, input logic [31:0] p, input logic [31:0] s);
        tbl_wr_en = 1; tbl_wr_idx = ix; tbl_wr_code = c; tbl_wr_ptr = p; tbl_wr_size = s;
    endtask

    task automatic drain();
        rmode = 1;
        for (int k = 0; k < 4; k++) tick();
    endtask

    bit done = 0;

    initial begin : main
        logic [RW-1:0] held;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 2048; i++) begin m_code[i] = 0; m_ptr[i] = 0; m_size[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        chk(!out_valid && in_ready, "R1 idle after reset", RW'({out_valid, in_ready}), RW'(2'b01));
        chk({cnt_accept, cnt_bad_fmt, cnt_bad_slice} == '0, "R1 counters zero", RW'(cnt_accept), '0);

        cur_req = "R1 R5 unwritten slice";
        set_pkt(16'h0123); send();

        cur_req = "R3 R4 upper VLAN bits";
        set_wr(11'h005, 4'd3, 32'h0010_0040, 32'd128); tick();
        set_pkt(16'hF805); send();
        set_pkt(16'h0005); send();
        drain();

        cur_req = "R2 bad tpid";     set_pkt(16'h0005); in_tpid = 16'h88A8; send();
        cur_req = "R2 bad ethertype"; set_pkt(16'h0005); in_ethertype = 16'h86DD; send();
        cur_req = "R2 bad protocol"; set_pkt(16'h0005); in_ip_proto = 8'd6; send();
        cur_req = "R2 bad format on off slice"; set_pkt(16'h0777); in_ip_proto = 8'd1; send();

        cur_req = "R6 size 55";  set_wr(11'h010, 4'd1, 32'h0000_1000, 32'd55); tick(); set_pkt(16'h0010); send();
        cur_req = "R6 size 56";  set_wr(11'h010, 4'd1, 32'h0000_1000, 32'd56); tick(); set_pkt(16'h0010); send();
        cur_req = "R6 misaligned"; set_wr(11'h011, 4'd2, 32'h0000_1002, 32'd200); tick(); set_pkt(16'h0011); send();
        cur_req = "R5 code zero"; set_wr(11'h012, 4'd0, 32'h0000_2000, 32'd200); tick(); set_pkt(16'h0012); send();
        drain();

        cur_req = "R11 same-edge write";
        set_wr(11'h020, 4'd7, 32'h0000_3000, 32'd64); tick();
        set_wr(11'h020, 4'd0, 32'h0000_3000, 32'd64); set_pkt(16'h0020); send();
        set_pkt(16'h0020); send();
        set_wr(11'h020, 4'd9, 32'h0000_4444, 32'd99); set_pkt(16'h0020); send();
        set_pkt(16'h0020); send();
        drain();

        cur_req = "R8 stall";
        rmode = 2;
        set_pkt(16'h0005); send();
        held = out_rec();
        set_pkt(16'h0005); in_valid = 1;
        for (int k = 0; k < 4; k++) begin
            tick();
            chk(!took && out_valid && out_rec() == held, "R8 hold under stall", out_rec(), held);
        end
        rmode = 1;
        send();
        drain();

        cur_req = "R10 random";
        rmode = 0;
        for (int n = 0; n < 400; n++) begin
            logic [15:0] tci;
            tci = {5'($urandom), 11'((($urandom % 8) * 37) + 3)};
            if (($urandom % 5) == 0) begin
                logic [31:0] sz;
                case ($urandom % 5)
                    0: sz = 32'd55; 1: sz = 32'd56; 2: sz = 32'd57; 3: sz = 32'd0; default: sz = 32'd300;
                endcase
                set_wr(11'((($urandom % 8) * 37) + 3), (($urandom % 8) == 0) ? 4'd0 : 4'($urandom),
                       {$urandom, (($urandom % 6) == 0) ? 2'b10 : 2'b00} >> 2 << 2 | (($urandom % 6) == 0 ? 32'd1 : 32'd0),
                       sz);
            end
            set_pkt(tci);
            case ($urandom % 10)
                0: in_tpid = 16'($urandom);
                1: in_ip_proto = 8'($urandom % 16);
                default: ;
            endcase
            send();
            if (($urandom % 3) == 0) tick();
        end
        drain();
        chk(expq.size() == 0, "R7 all records delivered", RW'(expq.size()), '0);
        chk(cnt_accept == '1 && cnt_bad_fmt == '1 && cnt_bad_slice == '1, "R10 saturated",
            RW'({cnt_accept, cnt_bad_fmt, cnt_bad_slice}), RW'({3*CW{1'b1}}));

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule